// File: doc/BRIEF.md
# Byte Sum-of-Absolute-Differences Accumulator

This unit is an execution slice for a small processor datapath. It takes two 32-bit register values, splits each into four unsigned bytes and finds the magnitude of the difference in each byte pair. It adds the four magnitudes and can fold a third register value into the total. Kernels such as block-matching motion search use it, with the block-distortion metric accumulated across rows.

The unit decodes the instruction word itself. It drives the three source register indices to the register file combinationally. It takes the operand values back and decides whether the result may be written. Accumulation has no opcode bit of its own. It is requested whenever the accumulator index field holds any value other than 15.

There are two pipeline stages. The first forms the per-lane magnitudes. The second forms the reduction and the accumulation. A valid flag travels alongside the data.

Top module: `byte_sad_accum`

## Requirements
- R1: Each byte lane i (bits 8i+7:8i) contributes the unsigned magnitude of the difference between the lane of `opnd_a` and the lane of `opnd_b`, an 8-bit value in the range 0..255 in whichever order the operands compare.
- R2: When no accumulation is requested, `result` is the sum of the four lane magnitudes, zero-extended to 32 bits, so it never exceeds 1020.
- R3: Instruction bits 15:12 hold the accumulator index. When that index is not 15, `acc_in` is added to the lane sum. When it is 15, `acc_in` has no effect on `result`.
- R4: The accumulation wraps modulo 2^32 and gives no overflow indication.
- R5: The unit presents these fields combinationally while `in_valid` is high: `rd_a_idx` = instruction bits 3:0, `rd_b_idx` = bits 11:8 and `rd_acc_idx` = bits 15:12. It presents `dst_idx` = bits 19:16 with the result.
- R6: `wr_en` is asserted only when instruction bits 24:20 equal 5'b11000.
- R7: When instruction bits 31:28 equal 4'hE, the write is enabled whatever the level of `cond_pass`. For any other code, the write is enabled only when `cond_pass` was high with the instruction.
- R8: `out_valid` follows `in_valid` exactly two clock edges later and is low out of reset, together with `wr_en`.
- R9: `wr_en` is never high while `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An instruction and its operands are present |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | Value of the register named by bits 3:0 |
| opnd_b | input | 32 | Value of the register named by bits 11:8 |
| acc_in | input | 32 | Value of the register named by bits 15:12 |
| cond_pass | input | 1 | Condition evaluation result for this instruction |
| rd_a_idx | output | 4 | First source register index |
| rd_b_idx | output | 4 | Second source register index |
| rd_acc_idx | output | 4 | Accumulator register index |
| out_valid | output | 1 | Result stage holds an instruction |
| wr_en | output | 1 | Result may be written to `dst_idx` |
| dst_idx | output | 4 | Destination register index |
| result | output | 32 | Sum of absolute differences, optionally accumulated |

## Verification
The assertions assume that the instruction word, the operands and `cond_pass` are stable and meaningful in each cycle in which `in_valid` is sampled. The shadow pipeline in the checker captures them at that edge. The bound on the sum assumes that only the accumulator field can enlarge the result. The bench therefore changes inputs only at the falling edge and keeps them fixed through the following rising edge. It inserts idle cycles with arbitrary data, so that `out_valid` and `wr_en` are shown not to depend on stale data.

// File: rtl/sadacc_pkg.sv
package sadacc_pkg;

  localparam int IDX_W        = 4;
  localparam int GRP_W        = 5;
  localparam int COND_W       = 4;

  localparam int A_IDX_LSB    = 0;
  localparam int B_IDX_LSB    = 8;
  localparam int ACC_IDX_LSB  = 12;
  localparam int DST_IDX_LSB  = 16;
  localparam int GRP_LSB      = 20;
  localparam int COND_LSB     = 28;

  localparam logic [GRP_W-1:0]  GROUP_CODE  = 5'b11000;
  localparam logic [COND_W-1:0] ALWAYS_CODE = 4'hE;
  localparam logic [IDX_W-1:0]  NO_ACC_IDX  = 4'hF;

  typedef struct packed {
    logic [IDX_W-1:0] a_idx;
    logic [IDX_W-1:0] b_idx;
    logic [IDX_W-1:0] acc_idx;
    logic [IDX_W-1:0] dst_idx;
    logic             group_hit;
    logic             uncond;
    logic             acc_on;
  } sad_decode_t;

endpackage

// File: rtl/sadacc_decode.sv
module sadacc_decode
  import sadacc_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic [INSTR_W-1:0] instr,
  output sad_decode_t        dec
);

  logic [COND_W-1:0] cond_field;
  logic [GRP_W-1:0]  grp_field;

  always_comb begin
    cond_field    = instr[COND_LSB +: COND_W];
    grp_field     = instr[GRP_LSB +: GRP_W];
    dec.a_idx     = instr[A_IDX_LSB +: IDX_W];
    dec.b_idx     = instr[B_IDX_LSB +: IDX_W];
    dec.acc_idx   = instr[ACC_IDX_LSB +: IDX_W];
    dec.dst_idx   = instr[DST_IDX_LSB +: IDX_W];
    dec.group_hit = (grp_field == GROUP_CODE);
    dec.uncond    = (cond_field == ALWAYS_CODE);
    dec.acc_on    = (instr[ACC_IDX_LSB +: IDX_W] != NO_ACC_IDX);
  end

endmodule

// File: rtl/sadacc_lane_diff.sv
module sadacc_lane_diff #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] mags
);

  // Subtract one bit wider than a lane, then negate on the borrow bit.
  function automatic logic [LANE_W-1:0] abs_diff(input logic [LANE_W-1:0] x,
                                                  input logic [LANE_W-1:0] y);
    logic [LANE_W:0] wide;
    wide = {1'b0, x} - {1'b0, y};
    return wide[LANE_W] ? (~wide[LANE_W-1:0] + 1'b1) : wide[LANE_W-1:0];
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mags[g*LANE_W +: LANE_W] = abs_diff(a[g*LANE_W +: LANE_W],
                                               b[g*LANE_W +: LANE_W]);
  end

endmodule

// File: rtl/sadacc_reduce.sv
module sadacc_reduce #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W,
  localparam int SUM_W  = LANE_W + $clog2(LANES)
) (
  input  logic [DATA_W-1:0] mags,
  input  logic [DATA_W-1:0] acc,
  input  logic              acc_on,
  output logic [DATA_W-1:0] total
);

  function automatic logic [SUM_W-1:0] lane_sum(input logic [DATA_W-1:0] v);
    logic [SUM_W-1:0] s;
    s = '0;
    for (int i = 0; i < LANES; i++) s = s + SUM_W'(v[i*LANE_W +: LANE_W]);
    return s;
  endfunction

  logic [SUM_W-1:0]  raw_sum;
  logic [DATA_W-1:0] addend;

  always_comb begin
    raw_sum = lane_sum(mags);
    addend  = acc_on ? acc : '0;
    total   = DATA_W'(raw_sum) + addend;
  end

endmodule

// File: rtl/byte_sad_accum.sv
module byte_sad_accum
  import sadacc_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int INSTR_W = 32,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              cond_pass,
  output logic [IDX_W-1:0]  rd_a_idx,
  output logic [IDX_W-1:0]  rd_b_idx,
  output logic [IDX_W-1:0]  rd_acc_idx,
  output logic              out_valid,
  output logic              wr_en,
  output logic [IDX_W-1:0]  dst_idx,
  output logic [DATA_W-1:0] result
);

  sad_decode_t       dec;
  logic [DATA_W-1:0] lane_mags;
  logic              s0_write_ok;

  sadacc_decode #(.INSTR_W(INSTR_W)) u_decode (
    .instr (instr),
    .dec   (dec)
  );

  assign rd_a_idx   = dec.a_idx;
  assign rd_b_idx   = dec.b_idx;
  assign rd_acc_idx = dec.acc_idx;
  assign s0_write_ok = in_valid & dec.group_hit & (dec.uncond | cond_pass);

  sadacc_lane_diff #(.LANES(LANES), .LANE_W(LANE_W)) u_diff (
    .a    (opnd_a),
    .b    (opnd_b),
    .mags (lane_mags)
  );

  // Stage 1: lane magnitudes and the context carried alongside them.
  logic              s1_valid;
  logic              s1_we;
  logic              s1_acc_on;
  logic [DATA_W-1:0] s1_mags;
  logic [DATA_W-1:0] s1_acc;
  logic [IDX_W-1:0]  s1_dst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_we     <= 1'b0;
      s1_acc_on <= 1'b0;
      s1_mags   <= '0;
      s1_acc    <= '0;
      s1_dst    <= '0;
    end else begin
      s1_valid  <= in_valid;
      s1_we     <= s0_write_ok;
      s1_acc_on <= dec.acc_on;
      s1_mags   <= lane_mags;
      s1_acc    <= acc_in;
      s1_dst    <= dec.dst_idx;
    end
  end

  logic [DATA_W-1:0] s1_total;

  sadacc_reduce #(.LANES(LANES), .LANE_W(LANE_W)) u_reduce (
    .mags   (s1_mags),
    .acc    (s1_acc),
    .acc_on (s1_acc_on),
    .total  (s1_total)
  );

  // Stage 2: reduced, accumulated result.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      dst_idx   <= '0;
      result    <= '0;
    end else begin
      out_valid <= s1_valid;
      wr_en     <= s1_valid & s1_we;
      dst_idx   <= s1_dst;
      result    <= s1_total;
    end
  end

endmodule

// File: rtl/sadacc_checker.sv
module sadacc_checker
  import sadacc_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int INSTR_W = 32,
  localparam int DATA_W = LANES * LANE_W,
  localparam int MAX_SUM = LANES * ((1 << LANE_W) - 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [INSTR_W-1:0] instr,
  input logic               cond_pass,
  input logic               out_valid,
  input logic               wr_en,
  input logic [DATA_W-1:0]  result
);

  logic v1, v2, skip1, skip2, always1, always2, miss1, miss2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {v1, v2, skip1, skip2, always1, always2, miss1, miss2} <= '0;
    end else begin
      v1      <= in_valid;
      skip1   <= (instr[15:12] == 4'hF);
      always1 <= (instr[24:20] == 5'b11000) && (instr[31:28] == 4'hE);
      miss1   <= (instr[24:20] != 5'b11000);
      v2      <= v1;
      skip2   <= skip1;
      always2 <= always1;
      miss2   <= miss1;
    end
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == v2);

  assert_we_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);

  assert_sum_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && skip2) |-> (result <= DATA_W'(MAX_SUM)));

  assert_uncond_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && always2) |-> wr_en);

  assert_group_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && miss2) |-> !wr_en);

endmodule

bind byte_sad_accum sadacc_checker #(
  .LANES(LANES), .LANE_W(LANE_W), .INSTR_W(INSTR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .instr     (instr),
  .cond_pass (cond_pass),
  .out_valid (out_valid),
  .wr_en     (wr_en),
  .result    (result)
);

// File: tb/byte_sad_accum_tb_top.sv
module byte_sad_accum_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0, opnd_a = '0, opnd_b = '0, acc_in = '0;
  logic        cond_pass = 1'b0;
  logic [3:0]  rd_a_idx, rd_b_idx, rd_acc_idx, dst_idx;
  logic        out_valid, wr_en;
  logic [31:0] result;

  always #5 clk = ~clk;

  byte_sad_accum dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_in(acc_in), .cond_pass(cond_pass),
    .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .rd_acc_idx(rd_acc_idx),
    .out_valid(out_valid), .wr_en(wr_en), .dst_idx(dst_idx), .result(result)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // expected values, one and two steps behind the drive
  logic e1_v = 0, e2_v = 0, e1_we = 0, e2_we = 0;
  logic [31:0] e1_res = '0, e2_res = '0;
  logic [3:0]  e1_dst = '0, e2_dst = '0;
  string       e1_tag = "R2", e2_tag = "R2";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] model_sad(input logic [31:0] a, input logic [31:0] b);
    int s = 0;
    for (int i = 0; i < 4; i++) begin
      int x = int'(a[8*i +: 8]);
      int y = int'(b[8*i +: 8]);
      s += (x >= y) ? (x - y) : (y - x);
    end
    return 32'(s);
  endfunction

  function automatic logic [31:0] mk(input logic [3:0] cnd, input logic [4:0] grp,
                                     input logic [3:0] dst, input logic [3:0] acc,
                                     input logic [3:0] rb, input logic [3:0] ra);
    return {cnd, 3'b011, grp, dst, acc, rb, 4'b0001, ra};
  endfunction

  task automatic step(input logic v, input logic [31:0] ins, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] acc, input logic cp,
                      input string tag);
    logic [31:0] r;
    @(negedge clk);
    chk(out_valid == e2_v, "R8", "out_valid", 32'(out_valid), 32'(e2_v));
    if (e2_v) begin
      chk(result == e2_res, e2_tag, "result", result, e2_res);
      chk(wr_en == e2_we, "R7", "wr_en", 32'(wr_en), 32'(e2_we));
      chk(dst_idx == e2_dst, "R5", "dst_idx", 32'(dst_idx), 32'(e2_dst));
    end else begin
      chk(wr_en == 1'b0, "R9", "wr_en idle", 32'(wr_en), 32'h0);
    end
    e2_v = e1_v; e2_we = e1_we; e2_res = e1_res; e2_dst = e1_dst; e2_tag = e1_tag;
    r = model_sad(a, b);
    if (ins[15:12] != 4'hF) r = r + acc;
    e1_v   = v;
    e1_res = r;
    e1_dst = ins[19:16];
    e1_we  = v && (ins[24:20] == 5'b11000) && ((ins[31:28] == 4'hE) || cp);
    e1_tag = tag;
    in_valid = v; instr = ins; opnd_a = a; opnd_b = b; acc_in = acc; cond_pass = cp;
    #1;
    if (v) begin
      chk(rd_a_idx == ins[3:0], "R5", "rd_a_idx", 32'(rd_a_idx), 32'(ins[3:0]));
      chk(rd_b_idx == ins[11:8], "R5", "rd_b_idx", 32'(rd_b_idx), 32'(ins[11:8]));
      chk(rd_acc_idx == ins[15:12], "R5", "rd_acc_idx", 32'(rd_acc_idx), 32'(ins[15:12]));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8", "reset out_valid", 32'(out_valid), 32'h0);
    chk(wr_en == 1'b0, "R8", "reset wr_en", 32'(wr_en), 32'h0);
    rst_n = 1'b1;

    // R2: zero and maximum lane sums, no accumulation
    step(1, mk(4'hE, 5'b11000, 4'd1, 4'hF, 4'd2, 4'd3), 32'h0, 32'h0, 32'h5, 0, "R2");
    step(1, mk(4'hE, 5'b11000, 4'd2, 4'hF, 4'd2, 4'd3), 32'hFFFFFFFF, 32'h0, 32'h0, 0, "R2");
    // R1: single-lane magnitudes in both orders
    step(1, mk(4'hE, 5'b11000, 4'd3, 4'hF, 4'd4, 4'd5), 32'h00000010, 32'h000000F0, 32'h0, 0, "R1");
    step(1, mk(4'hE, 5'b11000, 4'd4, 4'hF, 4'd4, 4'd5), 32'h05000000, 32'h80000000, 32'h0, 0, "R1");
    step(1, mk(4'hE, 5'b11000, 4'd4, 4'hF, 4'd4, 4'd5), 32'h0000FF00, 32'h00000100, 32'h0, 0, "R1");
    // R3: accumulate, and acc_in ignored with index 15
    step(1, mk(4'hE, 5'b11000, 4'd5, 4'd3, 4'd4, 4'd5), 32'h01020304, 32'h04030201, 32'd100, 0, "R3");
    step(1, mk(4'hE, 5'b11000, 4'd6, 4'hF, 4'd4, 4'd5), 32'h01020304, 32'h04030201, 32'hDEADBEEF, 0, "R3");
    // R4: wrap modulo 2^32
    step(1, mk(4'hE, 5'b11000, 4'd7, 4'd0, 4'd4, 4'd5), 32'h00000002, 32'h0, 32'hFFFFFFFF, 0, "R4");
    // R6: opcode group mismatch
    step(1, mk(4'hE, 5'b10000, 4'd8, 4'hF, 4'd4, 4'd5), 32'h11, 32'h22, 32'h0, 1, "R6");
    // R7: conditional codes
    step(1, mk(4'hE, 5'b11000, 4'd9, 4'hF, 4'd4, 4'd5), 32'h11, 32'h22, 32'h0, 0, "R7");
    step(1, mk(4'h0, 5'b11000, 4'd9, 4'hF, 4'd4, 4'd5), 32'h11, 32'h22, 32'h0, 0, "R7");
    step(1, mk(4'h0, 5'b11000, 4'd9, 4'hF, 4'd4, 4'd5), 32'h11, 32'h22, 32'h0, 1, "R7");
    // R8/R9: bubbles carrying garbage
    step(0, mk(4'hE, 5'b11000, 4'd9, 4'hF, 4'd4, 4'd5), 32'hAA, 32'h55, 32'h0, 1, "R8");
    step(0, 32'hFFFFFFFF, 32'h1, 32'h2, 32'h3, 1, "R9");

    for (int n = 0; n < 400; n++) begin
      logic [4:0] g = (($urandom % 10) < 7) ? 5'b11000 : 5'($urandom);
      logic [3:0] acf = (($urandom % 3) == 0) ? 4'hF : 4'($urandom);
      logic [3:0] cf = (($urandom % 2) == 0) ? 4'hE : 4'($urandom);
      logic [31:0] ins = mk(cf, g, 4'($urandom), acf, 4'($urandom), 4'($urandom));
      step(($urandom % 5) != 0, ins, $urandom, $urandom,
           (($urandom % 4) == 0) ? 32'hFFFFFF00 | 32'($urandom % 256) : $urandom,
           1'($urandom), (acf != 4'hF) ? "R3" : "R2");
    end

    step(0, 32'h0, 32'h0, 32'h0, 32'h0, 0, "R8");
    step(0, 32'h0, 32'h0, 32'h0, 32'h0, 0, "R8");
    step(0, 32'h0, 32'h0, 32'h0, 32'h0, 0, "R8");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule